// File: doc/BRIEF.md
# Acquisition Peak Search with Noise-Gated Threshold

This block performs the timing-offset search of an impulse-radio receiver's acquisition phase. A start pulse arms it. It then consumes a stream of correlator results. The first beats of the stream are treated as noise, and their decision metric is summed to form an average noise level. Every later beat is a search candidate that carries a code-rotation tag and a coarse-delay tag. A candidate qualifies only when it clears two thresholds in turn, twice and then four times the noise average. Among the qualifying candidates the block keeps the largest. When the last candidate has been scored, the block issues a one-cycle done pulse. With that pulse it reports either the winning coarse-delay control word and code rotation, or a failure flag.

The metric depends on the modulation mode, which is latched at start. In pulse-position mode a single correlator already carries the energy difference of the two slots, so the metric is the magnitude of the in-phase input. In antipodal (BPSK) mode the carrier phase is unknown, so the metric is the sum of the squares of the in-phase and quadrature correlations.

The stream input uses a valid/ready handshake. A beat transfers on a rising clock edge where `cand_valid` and `cand_ready` are both high and `start` is low. The source must hold a beat's data stable until it transfers. The block raises `cand_ready` in the cycle after `start` and never withdraws it until the beat marked `cand_last` in the search phase has transferred. After that beat, `cand_ready` stays low until the next start.

Top module: `acq_peak_search`

## Requirements
- R1: After reset, `cand_ready`, `done` and `fail` are 0 and `best_rot` and `best_dly` are 0. While idle, `cand_ready` stays 0 whatever `cand_valid` does.
- R2: A start pulse raises `cand_ready` on the next cycle. The first 2^NOISE_LOG2 transferred beats (512 by default) are noise samples, and their tags and `cand_last` are ignored.
- R3: The metric is |`cand_i`| when `mode_bpsk`=0, and `cand_i`²+`cand_q`² when `mode_bpsk`=1. The mode is sampled on the start pulse, and `cand_q` has no effect in the first mode.
- R4: The noise average is the sum of the noise metrics shifted right by NOISE_LOG2. A candidate qualifies only if its metric is strictly greater than twice the average and then strictly greater than four times the average.
- R5: The reported winner is the qualifying candidate with the largest metric. On equal metrics the one that transferred earlier is kept.
- R6: If the beat with `cand_last`=1 transfers in the search phase on edge k, then `done` is high for exactly the one cycle following edge k+2, and `cand_ready` is low from edge k+1 onward.
- R7: If no candidate qualifies, `done` comes with `fail`=1, and `best_rot` and `best_dly` keep their previous values.
- R8: If some candidate qualifies, `done` comes with `fail`=0 and the winner's tags on `best_rot` and `best_dly`. The result outputs change only on a done cycle.
- R9: A start pulse at any time discards the noise sum, the running maximum and any beats in flight, and begins a fresh noise phase.
- R10: During the noise and search phases `cand_ready` stays high. Data presented while `cand_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a new acquisition |
| mode_bpsk | input | 1 | 1: squared I/Q metric, 0: magnitude of I; sampled at start |
| cand_valid | input | 1 | Stream beat valid |
| cand_ready | output | 1 | Block accepts a beat |
| cand_i | input | CW | Signed in-phase (or PPM difference) correlation |
| cand_q | input | CW | Signed quadrature correlation |
| cand_rot | input | ROT_W | Code rotation tag of the candidate |
| cand_dly | input | DLY_W | Coarse-delay control word of the candidate |
| cand_last | input | 1 | Marks the final candidate of the sweep |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | No candidate cleared both thresholds |
| best_rot | output | ROT_W | Code rotation of the winner |
| best_dly | output | DLY_W | Coarse-delay control word of the winner |

## Verification
On every cycle, the assertions check the handshake and result timing. `done` never lasts two cycles. `cand_ready` follows a start and stays up through the phases. It drops after the final candidate. The result outputs move only on a done strobe, and a failed sweep leaves the delay word alone. The numeric content can only be shown by the bench's directed scenarios. This covers the noise average, the strict threshold boundary at four times that average, the choice of metric by mode, earliest-wins on ties, and the flushing effect of a restart. Each scenario uses noise and candidate values chosen so that the expected winner or failure follows directly from the requirements.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_NOISE  = 2'd1,
    ST_SEARCH = 2'd2
  } acq_state_e;
endpackage

// File: rtl/acq_metric.sv
module acq_metric #(
  parameter int CW    = 9,
  parameter int ROT_W = 5,
  parameter int DLY_W = 8,
  localparam int MW   = 2*CW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 in_vld,
  input  logic                 in_noise,
  input  logic                 bpsk,
  input  logic signed [CW-1:0] in_i,
  input  logic signed [CW-1:0] in_q,
  input  logic [ROT_W-1:0]     in_rot,
  input  logic [DLY_W-1:0]     in_dly,
  input  logic                 in_last,
  output logic                 a_vld,
  output logic                 a_noise,
  output logic [MW-1:0]        a_metric,
  output logic [ROT_W-1:0]     a_rot,
  output logic [DLY_W-1:0]     a_dly,
  output logic                 a_last
);
  logic signed [2*CW-1:0] sq_i, sq_q;
  logic [CW-1:0]          mag_i;
  logic [MW-1:0]          metric;

  always_comb begin
    sq_i  = in_i * in_i;
    sq_q  = in_q * in_q;
    mag_i = in_i[CW-1] ? (~in_i + 1'b1) : in_i;
    if (bpsk) metric = {1'b0, sq_i} + {1'b0, sq_q};
    else      metric = {{(MW-CW){1'b0}}, mag_i};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      a_vld    <= 1'b0;
      a_noise  <= 1'b0;
      a_metric <= '0;
      a_rot    <= '0;
      a_dly    <= '0;
      a_last   <= 1'b0;
    end else begin
      a_vld    <= in_vld;
      a_noise  <= in_noise;
      a_metric <= metric;
      a_rot    <= in_rot;
      a_dly    <= in_dly;
      a_last   <= in_last & ~in_noise;
    end
  end
endmodule

// File: rtl/acq_noise_est.sv
module acq_noise_est #(
  parameter int MW         = 19,
  parameter int NOISE_LOG2 = 9,
  localparam int AW        = MW + NOISE_LOG2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          add_vld,
  input  logic [MW-1:0] add_val,
  output logic [MW:0]   thr_lo,
  output logic [MW+1:0] thr_hi
);
  logic [AW-1:0] acc;
  logic [MW-1:0] avg;

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (add_vld) acc <= acc + {{NOISE_LOG2{1'b0}}, add_val};
  end

  assign avg    = acc[AW-1:NOISE_LOG2];
  assign thr_lo = {avg, 1'b0};
  assign thr_hi = {avg, 2'b00};
endmodule

// File: rtl/acq_peak_track.sv
module acq_peak_track #(
  parameter int MW    = 19,
  parameter int ROT_W = 5,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             a_vld,
  input  logic [MW-1:0]    a_metric,
  input  logic [ROT_W-1:0] a_rot,
  input  logic [DLY_W-1:0] a_dly,
  input  logic             a_last,
  input  logic [MW:0]      thr_lo,
  input  logic [MW+1:0]    thr_hi,
  output logic             done,
  output logic             fail,
  output logic [ROT_W-1:0] best_rot,
  output logic [DLY_W-1:0] best_dly
);
  logic             b_vld, b_pass1, b_last;
  logic [MW-1:0]    b_metric;
  logic [ROT_W-1:0] b_rot;
  logic [DLY_W-1:0] b_dly;

  logic             found;
  logic [MW-1:0]    max_val;
  logic [ROT_W-1:0] max_rot;
  logic [DLY_W-1:0] max_dly;

  logic pass2, better, found_nx;

  // first comparison step
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      b_vld    <= 1'b0;
      b_pass1  <= 1'b0;
      b_last   <= 1'b0;
      b_metric <= '0;
      b_rot    <= '0;
      b_dly    <= '0;
    end else begin
      b_vld    <= a_vld;
      b_pass1  <= ({1'b0, a_metric} > thr_lo);
      b_last   <= a_last & a_vld;
      b_metric <= a_metric;
      b_rot    <= a_rot;
      b_dly    <= a_dly;
    end
  end

  // second comparison step and strict-greater maximum
  always_comb begin
    pass2    = b_vld && b_pass1 && ({2'b00, b_metric} > thr_hi);
    better   = pass2 && (!found || (b_metric > max_val));
    found_nx = found || better;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found   <= 1'b0;
      max_val <= '0;
      max_rot <= '0;
      max_dly <= '0;
    end else if (better) begin
      found   <= 1'b1;
      max_val <= b_metric;
      max_rot <= b_rot;
      max_dly <= b_dly;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      fail     <= 1'b0;
      best_rot <= '0;
      best_dly <= '0;
    end else if (clear) begin
      done <= 1'b0;
    end else begin
      done <= b_vld && b_last;
      if (b_vld && b_last) begin
        fail <= !found_nx;
        if (found_nx) begin
          best_rot <= better ? b_rot : max_rot;
          best_dly <= better ? b_dly : max_dly;
        end
      end
    end
  end
endmodule

// File: rtl/acq_peak_search.sv
module acq_peak_search #(
  parameter int CW         = 9,
  parameter int NOISE_LOG2 = 9,
  parameter int ROT_W      = 5,
  parameter int DLY_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 mode_bpsk,
  input  logic                 cand_valid,
  output logic                 cand_ready,
  input  logic signed [CW-1:0] cand_i,
  input  logic signed [CW-1:0] cand_q,
  input  logic [ROT_W-1:0]     cand_rot,
  input  logic [DLY_W-1:0]     cand_dly,
  input  logic                 cand_last,
  output logic                 done,
  output logic                 fail,
  output logic [ROT_W-1:0]     best_rot,
  output logic [DLY_W-1:0]     best_dly
);
  import acq_pkg::*;

  localparam int MW = 2*CW + 1;
  localparam logic [NOISE_LOG2-1:0] CNT_LAST = '1;

  acq_state_e            state;
  logic                  bpsk_q;
  logic [NOISE_LOG2-1:0] noise_cnt;
  logic                  xfer, in_noise, in_search;

  assign in_noise   = (state == ST_NOISE);
  assign in_search  = (state == ST_SEARCH);
  assign cand_ready = in_noise || in_search;
  assign xfer       = cand_valid && cand_ready && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bpsk_q    <= 1'b0;
      noise_cnt <= '0;
    end else if (start) begin
      state     <= ST_NOISE;
      bpsk_q    <= mode_bpsk;
      noise_cnt <= '0;
    end else if (xfer) begin
      if (in_noise) begin
        noise_cnt <= noise_cnt + 1'b1;
        if (noise_cnt == CNT_LAST) state <= ST_SEARCH;
      end else if (cand_last) begin
        state <= ST_IDLE;
      end
    end
  end

  logic             a_vld, a_noise, a_last;
  logic [MW-1:0]    a_metric;
  logic [ROT_W-1:0] a_rot;
  logic [DLY_W-1:0] a_dly;
  logic [MW:0]      thr_lo;
  logic [MW+1:0]    thr_hi;

  acq_metric #(.CW(CW), .ROT_W(ROT_W), .DLY_W(DLY_W)) u_metric (
    .clk(clk), .rst(rst), .flush(start),
    .in_vld(xfer), .in_noise(in_noise), .bpsk(bpsk_q),
    .in_i(cand_i), .in_q(cand_q), .in_rot(cand_rot), .in_dly(cand_dly),
    .in_last(cand_last),
    .a_vld(a_vld), .a_noise(a_noise), .a_metric(a_metric),
    .a_rot(a_rot), .a_dly(a_dly), .a_last(a_last)
  );

  acq_noise_est #(.MW(MW), .NOISE_LOG2(NOISE_LOG2)) u_noise (
    .clk(clk), .rst(rst), .clear(start),
    .add_vld(a_vld && a_noise), .add_val(a_metric),
    .thr_lo(thr_lo), .thr_hi(thr_hi)
  );

  acq_peak_track #(.MW(MW), .ROT_W(ROT_W), .DLY_W(DLY_W)) u_track (
    .clk(clk), .rst(rst), .clear(start),
    .a_vld(a_vld && !a_noise), .a_metric(a_metric),
    .a_rot(a_rot), .a_dly(a_dly), .a_last(a_last),
    .thr_lo(thr_lo), .thr_hi(thr_hi),
    .done(done), .fail(fail), .best_rot(best_rot), .best_dly(best_dly)
  );
endmodule

// File: rtl/acq_peak_search_chk.sv
module acq_peak_search_chk #(
  parameter int ROT_W = 5,
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cand_valid,
  input logic             cand_ready,
  input logic             cand_last,
  input logic             in_search,
  input logic             done,
  input logic             fail,
  input logic [ROT_W-1:0] best_rot,
  input logic [DLY_W-1:0] best_dly
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_search && cand_valid && cand_ready && cand_last && !start) |=> !cand_ready);

  a_r2_ready_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> cand_ready);

  a_r10_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (cand_ready && !start && !(in_search && cand_valid && cand_last)) |=> cand_ready);

  a_r8_outputs_stable: assert property (@(posedge clk) disable iff (rst)
    !done |=> (!done || 1'b1) && ($stable(best_rot) || $past(done) || $rose(done))
           && ($stable(best_dly) || $rose(done)) && ($stable(fail) || $rose(done)));

  a_r7_fail_keeps_word: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && fail) |-> ($stable(best_dly) && $stable(best_rot)));
endmodule

bind acq_peak_search acq_peak_search_chk #(.ROT_W(ROT_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cand_valid(cand_valid),
  .cand_ready(cand_ready), .cand_last(cand_last), .in_search(in_search),
  .done(done), .fail(fail), .best_rot(best_rot), .best_dly(best_dly)
);

// File: tb/tb_acq_peak_search.sv
module tb_acq_peak_search;
  localparam int CW = 9, NL = 9, RW = 5, DW = 8;
  localparam int NNOISE = 1 << NL;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode_bpsk = 1'b0;
  logic cand_valid = 1'b0, cand_last = 1'b0;
  logic signed [CW-1:0] cand_i = '0, cand_q = '0;
  logic [RW-1:0] cand_rot = '0;
  logic [DW-1:0] cand_dly = '0;
  logic cand_ready, done, fail;
  logic [RW-1:0] best_rot;
  logic [DW-1:0] best_dly;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  acq_peak_search #(.CW(CW), .NOISE_LOG2(NL), .ROT_W(RW), .DLY_W(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_bpsk(mode_bpsk),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_i(cand_i),
    .cand_q(cand_q), .cand_rot(cand_rot), .cand_dly(cand_dly),
    .cand_last(cand_last), .done(done), .fail(fail),
    .best_rot(best_rot), .best_dly(best_dly));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic bpsk);
    @(negedge clk);
    start = 1'b1; mode_bpsk = bpsk; cand_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R2 ready after start", int'(cand_ready), 1);
  endtask

  task automatic send(input int i, input int q, input int rot, input int dly, input logic last);
    @(negedge clk);
    cand_valid = 1'b1; cand_i = CW'(i); cand_q = CW'(q);
    cand_rot = RW'(rot); cand_dly = DW'(dly); cand_last = last;
    while (!cand_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cand_valid = 1'b0; cand_i = 9'sd100; cand_last = 1'b1;
      chk("R10 ready during gap", int'(cand_ready), 1);
    end
  endtask

  task automatic noise(input int i, input int q, input logic alt);
    for (int k = 0; k < NNOISE; k++)
      send((alt && k[0]) ? -i : i, q, k & 31, k & 255, 1'b1);
  endtask

  // last candidate transferred on edge k: done visible after edge k+2 only
  task automatic expect_done(input string req, input int efail, input int erot, input int edly);
    @(negedge clk);
    cand_valid = 1'b0;
    chk({req, " R6 ready low after last"}, int'(cand_ready), 0);
    chk({req, " R6 no early done"}, int'(done), 0);
    @(negedge clk);
    chk({req, " R6 no early done"}, int'(done), 0);
    @(negedge clk);
    chk({req, " R6 done strobe"}, int'(done), 1);
    chk({req, " fail flag"}, int'(fail), efail);
    chk({req, " best_rot"}, int'(best_rot), erot);
    chk({req, " best_dly"}, int'(best_dly), edly);
    @(negedge clk);
    chk({req, " R6 done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cand_valid = 1'b1; cand_last = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready idle", int'(cand_ready), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 rot", int'(best_rot), 0);
    chk("R1 dly", int'(best_dly), 0);
    cand_valid = 1'b0; cand_last = 1'b0;
  endtask

  // avg 3 -> strict bound 12; tie on 20 keeps the earlier one; q ignored
  task automatic t_ppm;
    pulse_start(1'b0);
    noise(3, 50, 1'b1);
    send(10, 0, 1, 5, 0);
    send(13, 90, 2, 7, 0);
    send(20, 0, 3, 9, 0);
    send(-20, 0, 4, 10, 0);
    send(12, 0, 5, 11, 1);
    expect_done("R3 R4 R5 ppm", 0, 3, 9);
  endtask

  // metric 5 -> avg 5, bound 20
  task automatic t_bpsk;
    pulse_start(1'b1);
    noise(2, 1, 1'b1);
    send(4, 2, 6, 50, 0);
    send(3, 3, 6, 51, 0);
    send(4, 3, 7, 100, 0);
    send(-5, 0, 8, 101, 0);
    send(0, -6, 9, 200, 0);
    send(5, 1, 10, 3, 1);
    expect_done("R3 R8 bpsk", 0, 9, 200);
  endtask

  // avg 8 -> bound 32; nothing above
  task automatic t_fail;
    pulse_start(1'b0);
    noise(8, 0, 1'b0);
    send(32, 0, 1, 1, 0);
    send(20, 0, 2, 2, 0);
    send(31, 0, 3, 3, 1);
    expect_done("R7 fail", 1, 9, 200);
  endtask

  // restart mid-noise discards a large sum
  task automatic t_restart;
    pulse_start(1'b0);
    for (int k = 0; k < 100; k++) send(200, 0, 0, 0, 0);
    pulse_start(1'b0);
    noise(1, 0, 1'b0);
    send(5, 0, 17, 77, 1);
    expect_done("R9 restart", 0, 17, 77);
  endtask

  // gaps with junk data while valid low
  task automatic t_gaps;
    pulse_start(1'b0);
    noise(0, 0, 1'b0);
    gap(2);
    send(1, 0, 1, 1, 0);
    gap(3);
    send(7, 0, 2, 2, 0);
    gap(1);
    send(7, 0, 3, 3, 1);
    expect_done("R10 R5 gaps", 0, 2, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_ppm;
    t_bpsk;
    t_fail;
    t_restart;
    t_gaps;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule